// File: doc/BRIEF.md
# BCD Clock and Calendar Counter Chain

This block keeps wall-clock time and the calendar in packed BCD. It is advanced by a one-cycle enable pulse at 32,768 Hz, `ref_tick`, which arrives in the system clock domain. A fractional accumulator turns that rate into exactly 100 steps per second. Each step advances a chain that holds tenths and hundredths, seconds, minutes, 24-hour hours, weekday, day of month, month and two-digit year. A single century flag sits above the year.

A host sets the time with a single-cycle parallel load of all eight bytes and the century flag. The current time is always visible on a 64-bit read port. Byte 0 (bits 7:0) holds the sub-second value. Byte 1 holds seconds, byte 2 minutes, byte 3 hours, byte 4 weekday, byte 5 day of month, byte 6 month and byte 7 (bits 63:56) the year. Every byte holds two BCD digits, with the tens digit in the upper nibble.

Top module: `rtc_bcd_chain`

## Requirements
- R1: After reset the read port shows 00.00 sub-seconds, 00 seconds, 00 minutes, 00 hours, weekday 01, date 01, month 01 and year 00, and the century flag is 0.
- R2: With `ref_tick` high on every cycle after a load, the sub-second byte first advances on the 329th clock edge after the load edge. Exactly 100 sub-second steps occur per 32,768 reference ticks, so seconds advance on the 32,769th edge.
- R3: The sub-second byte holds tenths in bits 7:4 and hundredths in bits 3:0. It counts 00 to 99, and its wrap from 99 to 00 advances seconds in the same edge.
- R4: Seconds and minutes wrap from 59 to 00, and each wrap carries into the next field in the same edge.
- R5: Hours count in 24-hour form and wrap from 23 to 00. That wrap advances the weekday and the date.
- R6: The weekday counts 01 to 07 and returns to 01 after 07.
- R7: The date returns to 01 after 30 in months 04, 06, 09 and 11. It returns to 01 after 31 in the other months except 02, and each return advances the month.
- R8: In month 02 the date returns to 01 after 29 when the year value is divisible by 4, and after 28 otherwise.
- R9: The month wraps from 12 to 01 and advances the year.
- R10: The year wraps from 99 to 00 and inverts the century flag.
- R11: When `load_en` is high at an edge, all eight bytes and the century flag take the load values at that edge, and the sub-second accumulator is cleared. No count step is applied in that cycle.
- R12: While `ref_tick` stays low, the read port and the century flag do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable at the 32,768 Hz reference rate |
| load_en | input | 1 | Load all time fields this cycle |
| load_time | input | 64 | Eight BCD bytes to load, same layout as `time_o` |
| load_century | input | 1 | Century flag value to load |
| time_o | output | 64 | Current time as eight BCD bytes |
| century_o | output | 1 | Current century flag |

## Verification
A load shows on `time_o` at the edge that samples `load_en`, so the bench reads the loaded value at the falling edge right after it. With `ref_tick` held high, the prescaler pulse is registered at the 328th edge after the load. The counters move at the 329th edge, and every carry in the chain lands in that same edge. The bench therefore samples once after edge 328, expecting no change, and once after edge 329, expecting the value from its own calendar model. The hundred-steps-per-second check samples after edges 32,768 and 32,769.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_BYTES = 8;

  typedef logic [BYTE_W-1:0] bcd_byte_t;

  // next BCD value, no wrap handling
  function automatic bcd_byte_t bcd_inc(input bcd_byte_t v);
    bcd_byte_t r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // last day of a month, BCD in, BCD out
  function automatic bcd_byte_t month_last(input bcd_byte_t month, input bcd_byte_t year);
    logic [6:0] yb;
    bcd_byte_t  r;
    yb = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
    case (month)
      8'h02:                      r = (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_frac_prescaler.sv
module rtc_frac_prescaler #(
  parameter int REF_HZ = 32768,
  parameter int OUT_HZ = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick_in,
  output logic tick_out
);
  localparam int AW = $clog2(REF_HZ + OUT_HZ);
  localparam logic [AW-1:0] REF_W = AW'(REF_HZ);
  localparam logic [AW-1:0] OUT_W = AW'(OUT_HZ);

  logic [AW-1:0] acc;
  logic [AW-1:0] sum;

  assign sum = acc + OUT_W;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc      <= '0;
      tick_out <= 1'b0;
    end else begin
      tick_out <= 1'b0;
      if (tick_in) begin
        if (sum >= REF_W) begin
          acc      <= sum - REF_W;
          tick_out <= 1'b1;
        end else begin
          acc <= sum;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap
  import rtc_pkg::*;
#(
  parameter bcd_byte_t LAST = 8'h59
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  bcd_byte_t load_val,
  input  logic      inc,
  output bcd_byte_t value,
  output logic      carry_out
);
  assign carry_out = inc && (value == LAST);

  always_ff @(posedge clk) begin
    if (rst)            value <= '0;
    else if (load)      value <= load_val;
    else if (carry_out) value <= '0;
    else if (inc)       value <= bcd_inc(value);
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  bcd_byte_t ld_dow,
  input  bcd_byte_t ld_date,
  input  bcd_byte_t ld_month,
  input  bcd_byte_t ld_year,
  input  logic      ld_century,
  input  logic      day_inc,
  output bcd_byte_t dow,
  output bcd_byte_t date,
  output bcd_byte_t month,
  output bcd_byte_t year,
  output logic      century
);
  logic month_end;
  logic year_end;
  logic cent_end;

  assign month_end = day_inc && (date == month_last(month, year));
  assign year_end  = month_end && (month == 8'h12);
  assign cent_end  = year_end && (year == 8'h99);

  always_ff @(posedge clk) begin
    if (rst) begin
      dow     <= 8'h01;
      date    <= 8'h01;
      month   <= 8'h01;
      year    <= 8'h00;
      century <= 1'b0;
    end else if (load) begin
      dow     <= ld_dow;
      date    <= ld_date;
      month   <= ld_month;
      year    <= ld_year;
      century <= ld_century;
    end else if (day_inc) begin
      dow  <= (dow == 8'h07) ? 8'h01 : bcd_inc(dow);
      date <= month_end ? 8'h01 : bcd_inc(date);
      if (month_end) month <= year_end ? 8'h01 : bcd_inc(month);
      if (year_end)  year  <= cent_end ? 8'h00 : bcd_inc(year);
      if (cent_end)  century <= ~century;
    end
  end
endmodule

// File: rtl/rtc_bcd_chain.sv
module rtc_bcd_chain
  import rtc_pkg::*;
#(
  parameter int REF_HZ = 32768,
  parameter int STEP_HZ = 100
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ref_tick,
  input  logic                        load_en,
  input  logic [NUM_BYTES*BYTE_W-1:0] load_time,
  input  logic                        load_century,
  output logic [NUM_BYTES*BYTE_W-1:0] time_o,
  output logic                        century_o
);
  localparam int NUM_WRAP = 4;
  localparam bcd_byte_t WRAP_LAST [NUM_WRAP] = '{8'h99, 8'h59, 8'h59, 8'h23};

  logic                hund_step;
  logic [NUM_WRAP:0]   carry;
  bcd_byte_t           wrap_val [NUM_WRAP];
  bcd_byte_t           dow, date, month, year;

  rtc_frac_prescaler #(.REF_HZ(REF_HZ), .OUT_HZ(STEP_HZ)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .clr     (load_en),
    .tick_in (ref_tick),
    .tick_out(hund_step)
  );

  assign carry[0] = hund_step && !load_en;

  for (genvar i = 0; i < NUM_WRAP; i++) begin : g_wrap
    rtc_bcd_wrap #(.LAST(WRAP_LAST[i])) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (load_en),
      .load_val (load_time[i*BYTE_W +: BYTE_W]),
      .inc      (carry[i]),
      .value    (wrap_val[i]),
      .carry_out(carry[i+1])
    );
    assign time_o[i*BYTE_W +: BYTE_W] = wrap_val[i];
  end

  rtc_calendar u_cal (
    .clk       (clk),
    .rst       (rst),
    .load      (load_en),
    .ld_dow    (load_time[4*BYTE_W +: BYTE_W]),
    .ld_date   (load_time[5*BYTE_W +: BYTE_W]),
    .ld_month  (load_time[6*BYTE_W +: BYTE_W]),
    .ld_year   (load_time[7*BYTE_W +: BYTE_W]),
    .ld_century(load_century),
    .day_inc   (carry[NUM_WRAP]),
    .dow       (dow),
    .date      (date),
    .month     (month),
    .year      (year),
    .century   (century_o)
  );

  assign time_o[4*BYTE_W +: BYTE_W] = dow;
  assign time_o[5*BYTE_W +: BYTE_W] = date;
  assign time_o[6*BYTE_W +: BYTE_W] = month;
  assign time_o[7*BYTE_W +: BYTE_W] = year;
endmodule

// File: rtl/rtc_bcd_chain_chk.sv
module rtc_bcd_chain_chk (
  input logic        clk,
  input logic        rst,
  input logic        load_en,
  input logic [63:0] load_time,
  input logic        load_century,
  input logic [63:0] time_o,
  input logic        century_o,
  input logic        step
);
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (time_o == $past(load_time)) && (century_o == $past(load_century))); // R11

  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    step |=> !step); // R2

  AST_HUND_MOVES: assert property (@(posedge clk) disable iff (rst)
    (step && !load_en) |=> (time_o[7:0] != $past(time_o[7:0]))); // R3

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !load_en && time_o[7:0] == 8'h99 && time_o[15:8] == 8'h59)
      |=> (time_o[15:8] == 8'h00)); // R4

  AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !load_en && time_o[31:0] == 32'h2359_5999) |=> (time_o[31:24] == 8'h00)); // R5

  AST_CENTURY_FLIP: assert property (@(posedge clk) disable iff (rst)
    (!$stable(century_o) && !$past(load_en)) |-> ($past(time_o[63:56]) == 8'h99)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !step) |=> ($stable(time_o) && $stable(century_o))); // R12
endmodule

bind rtc_bcd_chain rtc_bcd_chain_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .load_en     (load_en),
  .load_time   (load_time),
  .load_century(load_century),
  .time_o      (time_o),
  .century_o   (century_o),
  .step        (hund_step)
);

// File: tb/test_rtc_bcd_chain.sv
module test_rtc_bcd_chain;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b1;
  logic        load_en = 1'b0;
  logic [63:0] load_time = '0;
  logic        load_century = 1'b0;
  logic [63:0] time_o;
  logic        century_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rtc_bcd_chain i_rtc_bcd_chain (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .load_en(load_en),
    .load_time(load_time), .load_century(load_century),
    .time_o(time_o), .century_o(century_o)
  );

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    logic [7:0] r;
    r[7:4] = 4'(v / 10);
    r[3:0] = 4'(v % 10);
    return r;
  endfunction

  function automatic int days_in(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [64:0] mk(input int c, input int yr, input int mo, input int dt,
                                     input int dw, input int hr, input int mi, input int se,
                                     input int hu);
    return {c[0], i2b(yr), i2b(mo), i2b(dt), i2b(dw), i2b(hr), i2b(mi), i2b(se), i2b(hu)};
  endfunction

  // expected state one hundredth later
  function automatic logic [64:0] model_next(input logic [64:0] s);
    int hu, se, mi, hr, dw, dt, mo, yr, c;
    hu = b2i(s[7:0]);   se = b2i(s[15:8]);  mi = b2i(s[23:16]); hr = b2i(s[31:24]);
    dw = b2i(s[39:32]); dt = b2i(s[47:40]); mo = b2i(s[55:48]); yr = b2i(s[63:56]);
    c  = int'(s[64]);
    hu++;
    if (hu == 100) begin
      hu = 0; se++;
      if (se == 60) begin
        se = 0; mi++;
        if (mi == 60) begin
          mi = 0; hr++;
          if (hr == 24) begin
            hr = 0;
            dw = (dw == 7) ? 1 : dw + 1;
            dt++;
            if (dt > days_in(mo, yr)) begin
              dt = 1; mo++;
              if (mo == 13) begin
                mo = 1; yr++;
                if (yr == 100) begin yr = 0; c = 1 - c; end
              end
            end
          end
        end
      end
    end
    return mk(c, yr, mo, dt, dw, hr, mi, se, hu);
  endfunction

  task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [64:0] s);
    @(negedge clk);
    load_time = s[63:0]; load_century = s[64]; load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
    check("R11 load", {century_o, time_o}, s);
  endtask

  // load, confirm nothing moves through edge 328, then one step at edge 329
  task automatic step_check(input string tag, input logic [64:0] s);
    do_load(s);
    repeat (328) @(posedge clk);
    @(negedge clk);
    check("R2 first step not before edge 329", {century_o, time_o}, s);
    @(posedge clk);
    @(negedge clk);
    check(tag, {century_o, time_o}, model_next(s));
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [64:0] s;
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R1 reset", {century_o, time_o}, mk(0, 0, 1, 1, 1, 0, 0, 0, 0));

    // directed corners
    step_check("R3 tenths digit", mk(0, 10, 3, 5, 2, 12, 34, 56, 9));
    step_check("R3 sub-second wrap", mk(0, 10, 3, 5, 2, 12, 34, 56, 99));
    step_check("R4 second and minute wrap", mk(0, 10, 3, 5, 2, 10, 59, 59, 99));
    step_check("R5 hour wrap", mk(0, 10, 3, 15, 3, 23, 59, 59, 99));
    step_check("R6 weekday wrap", mk(0, 10, 3, 15, 7, 23, 59, 59, 99));
    step_check("R7 30-day month", mk(0, 10, 4, 30, 1, 23, 59, 59, 99));
    step_check("R7 31-day month", mk(0, 10, 1, 31, 1, 23, 59, 59, 99));
    step_check("R7 no early wrap", mk(0, 10, 4, 29, 1, 23, 59, 59, 99));
    step_check("R8 leap 28th", mk(0, 24, 2, 28, 1, 23, 59, 59, 99));
    step_check("R8 leap 29th", mk(0, 24, 2, 29, 1, 23, 59, 59, 99));
    step_check("R8 common 28th", mk(0, 23, 2, 28, 1, 23, 59, 59, 99));
    step_check("R9 month wrap", mk(0, 45, 12, 31, 4, 23, 59, 59, 99));
    step_check("R10 century set", mk(0, 99, 12, 31, 5, 23, 59, 59, 99));
    step_check("R10 century clear", mk(1, 99, 12, 31, 5, 23, 59, 59, 99));

    // R12: no reference ticks, no motion
    ref_tick = 1'b0;
    s = mk(0, 50, 6, 10, 3, 8, 30, 15, 42);
    do_load(s);
    repeat (1000) @(posedge clk);
    @(negedge clk);
    check("R12 idle without ticks", {century_o, time_o}, s);
    ref_tick = 1'b1;

    // R2: 100 steps per 32768 ticks
    s = mk(0, 1, 1, 1, 1, 0, 0, 0, 0);
    do_load(s);
    repeat (32768) @(posedge clk);
    @(negedge clk);
    check("R2 99th step", {century_o, time_o}, mk(0, 1, 1, 1, 1, 0, 0, 0, 99));
    @(posedge clk);
    @(negedge clk);
    check("R2 one second", {century_o, time_o}, mk(0, 1, 1, 1, 1, 0, 0, 1, 0));

    // constrained random: valid times, biased toward carries
    for (int k = 0; k < 40; k++) begin
      int yr, mo, dt;
      yr = int'($urandom_range(99));
      mo = int'($urandom_range(12, 1));
      dt = ($urandom_range(1) == 1) ? days_in(mo, yr) : int'($urandom_range(days_in(mo, yr), 1));
      s = mk(int'($urandom_range(1)), yr, mo, dt, int'($urandom_range(7, 1)),
             ($urandom_range(1) == 1) ? 23 : int'($urandom_range(23)),
             ($urandom_range(1) == 1) ? 59 : int'($urandom_range(59)),
             ($urandom_range(1) == 1) ? 59 : int'($urandom_range(59)),
             ($urandom_range(1) == 1) ? 99 : int'($urandom_range(99)));
      step_check("R3 random step", s);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule